// File: doc/BRIEF.md
# Flash Program-Write Unlock Controller

This block sits between a processor's register bus and the programming port of an on-chip nonvolatile program memory. Software cannot start a program write with a single store. It must first set a write-enable bit, then write a two-byte key to a key address that stores nothing, and only then set the start bit. Only a start request that follows the key directly is accepted.

While a write is running, the block holds the processor in a stall, keeps a programming request asserted towards the memory, and waits for the memory's done pulse. A select bit, captured when the write starts, steers the access to the configuration space or to the normal program space. If a system reset arrives while a write is running, the write is dropped and a sticky error bit is set. That bit survives the system reset, so software can find the damaged location and write it again. The memory handshake is plain control: a level request and a one-cycle done pulse, with no back-pressure.

Top module: `flash_wr_guard`

## Requirements
- R1: A write start is accepted only if the control byte that sets START (bit 0) also has WEN (bit 1) set to 1. Otherwise nothing starts and START reads 0.
- R2: A write starts only after this sequence: 0x55 written to the key address (1), then 0xAA written to the key address, then a control write (address 0) with START = 1. No other sequence starts a write.
- R3: A read of the key address always returns 0x00. A read of an unused address also returns 0x00.
- R4: `stall` and `prog_req` go high in the cycle after the start is accepted. They stay high until the cycle after `prog_done` is seen.
- R5: START reads 1 while a write runs and clears on its own after `prog_done`. A control write with START = 0 during a write does not clear it.
- R6: If `rst_n` is low at a clock edge while a write runs, the write ends, ERR (bit 2) is set, and WEN, CFG and START clear.
- R7: Any bus write other than the next expected key byte returns the key checker to idle. This includes a wrong value, or a write to any other address, made between the two key bytes or before the start.
- R8: After every completed or aborted write, a new write needs a fresh 0x55/0xAA sequence.
- R9: CFG (bit 3) is taken from the accepted start write and driven on `prog_cfg` for the whole write. Control writes made during the write do not change it.
- R10: ERR is not cleared by `rst_n`. It clears only when software writes 0 to bit 2 with `rst_n` high, or when `por_n` goes low. Writing 1 to bit 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset (external or watchdog), active low, synchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous for ERR |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 key) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| stall | output | 1 | Processor stall while programming |
| prog_req | output | 1 | Programming request to memory |
| prog_cfg | output | 1 | 1 = configuration space, 0 = program space |
| prog_done | input | 1 | One-cycle completion pulse from memory |

## Verification
The bench uses the default two-bit address and the 0x55/0xAA key values. Its memory stub answers after six cycles. That window is short enough that a control write, a register read and a system-reset pulse can all land while a write is still running, so the no-clear rule, the latched select bit and the abort path can each be checked in the middle of a write.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  typedef enum logic [1:0] {KS_IDLE, KS_HALF, KS_ARMED} key_st_t;
  localparam int B_START = 0;
  localparam int B_WEN   = 1;
  localparam int B_ERR   = 2;
  localparam int B_CFG   = 3;
endpackage

// File: rtl/fg_key_seq.sv
module fg_key_seq
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int KEY_ADDR = 1,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              busy_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic              armed_o
);
  key_st_t state_q;
  logic    key_hit;

  assign key_hit = (bus_addr == ADDR_W'(KEY_ADDR));

  // any write that is not the next expected key byte drops back to idle (R7)
  always_ff @(posedge clk) begin
    if (rst_i || busy_i) state_q <= KS_IDLE;
    else if (bus_wr) begin
      case (state_q)
        KS_IDLE: state_q <= (key_hit && bus_wdata == KEY_A) ? KS_HALF : KS_IDLE;
        KS_HALF: state_q <= (key_hit && bus_wdata == KEY_B) ? KS_ARMED : KS_IDLE;
        default: state_q <= KS_IDLE;
      endcase
    end
  end

  assign armed_o = (state_q == KS_ARMED);

  // R8: a running write always disarms the checker
  p_rearm_r8: assert property (@(posedge clk) disable iff (rst_i)
    busy_i |=> !armed_o);
endmodule

// File: rtl/fg_ctrl.sv
module fg_ctrl (
  input  logic clk,
  input  logic rst_i,
  input  logic ctrl_wr,
  input  logic wd_start,
  input  logic wd_wen,
  input  logic wd_cfg,
  input  logic armed_i,
  input  logic prog_done,
  output logic busy_o,
  output logic wen_o,
  output logic cfg_o
);
  logic start_go;

  assign start_go = ctrl_wr && armed_i && !busy_o && wd_start && wd_wen;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      busy_o <= 1'b0;
      wen_o  <= 1'b0;
      cfg_o  <= 1'b0;
    end else begin
      if (start_go)                 busy_o <= 1'b1;
      else if (busy_o && prog_done) busy_o <= 1'b0;
      if (ctrl_wr) begin
        wen_o <= wd_wen;
        if (!busy_o) cfg_o <= wd_cfg;
      end
    end
  end

  p_start_armed_r2: assert property (@(posedge clk) disable iff (rst_i)
    $rose(busy_o) |-> $past(armed_i));
  p_start_wen_r1: assert property (@(posedge clk) disable iff (rst_i)
    $rose(busy_o) |-> wen_o);
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (rst_i)
    (busy_o && !prog_done) |=> busy_o);
  p_cfg_stable_r9: assert property (@(posedge clk) disable iff (rst_i)
    (busy_o && $past(busy_o)) |-> $stable(cfg_o));
endmodule

// File: rtl/fg_err.sv
module fg_err (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_n,
  input  logic busy_i,
  input  logic clr_wr,
  output logic err_o
);
  // only power-on clears this flop asynchronously; system reset does not
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      err_o <= 1'b0;
    else if (!sys_rst_n && busy_i)   err_o <= 1'b1;
    else if (clr_wr && sys_rst_n)    err_o <= 1'b0;
  end

  p_abort_sets_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && busy_i) |=> err_o);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
    (err_o && !(clr_wr && sys_rst_n)) |=> err_o);
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CTRL_ADDR = 0,
  parameter int KEY_ADDR = 1,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              stall,
  output logic              prog_req,
  output logic              prog_cfg,
  input  logic              prog_done
);
  logic sys_rst, ctrl_wr, armed, busy, wen, cfg, err;

  assign sys_rst = !rst_n || !por_n;
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

  fg_key_seq #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_i(sys_rst), .busy_i(busy), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .armed_o(armed));

  fg_ctrl u_ctrl (
    .clk(clk), .rst_i(sys_rst), .ctrl_wr(ctrl_wr),
    .wd_start(bus_wdata[B_START]), .wd_wen(bus_wdata[B_WEN]), .wd_cfg(bus_wdata[B_CFG]),
    .armed_i(armed), .prog_done(prog_done),
    .busy_o(busy), .wen_o(wen), .cfg_o(cfg));

  fg_err u_err (
    .clk(clk), .por_n(por_n), .sys_rst_n(rst_n), .busy_i(busy),
    .clr_wr(ctrl_wr && !bus_wdata[B_ERR]), .err_o(err));

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata[B_START] = busy;
      bus_rdata[B_WEN]   = wen;
      bus_rdata[B_ERR]   = err;
      bus_rdata[B_CFG]   = cfg;
    end
  end

  assign stall    = busy;
  assign prog_req = busy;
  assign prog_cfg = cfg;

  p_key_reads_zero_r3: assert property (@(posedge clk) disable iff (sys_rst)
    (bus_addr == ADDR_W'(KEY_ADDR)) |-> (bus_rdata == 8'h00));
  p_stall_until_done_r4: assert property (@(posedge clk) disable iff (sys_rst)
    (stall && !prog_done) |=> stall);
endmodule

// File: tb/flash_wr_guard_test.sv
module flash_wr_guard_test;
  localparam int CLK_P = 10;
  localparam int PROG_CYCLES = 6;

  logic clk = 0, rst_n = 0, por_n = 0, bus_wr = 0, prog_done;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic stall, prog_req, prog_cfg;
  int n_chk = 0, n_fail = 0;
  int cnt = 0;
  logic exp_cfg[$];
  logic prev_req = 0;
  logic [7:0] rv;

  flash_wr_guard uut (.clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stall(stall), .prog_req(prog_req), .prog_cfg(prog_cfg), .prog_done(prog_done));

  initial forever #(CLK_P/2) clk = ~clk;

  // memory stub: done pulse after PROG_CYCLES cycles of request
  always @(posedge clk) cnt <= prog_req ? cnt + 1 : 0;
  assign prog_done = prog_req && (cnt == PROG_CYCLES - 1);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: each started write must match the next scoreboard entry (R2, R9)
  initial forever begin
    @(negedge clk);
    if (prog_req && !prev_req) begin
      if (exp_cfg.size() == 0) chk("R2 unexpected start", 8'd1, 8'd0);
      else chk("R9 prog_cfg", {7'd0, prog_cfg}, {7'd0, exp_cfg.pop_front()});
    end
    prev_req = prog_req;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic keys();
    wr(1, 8'h55); wr(1, 8'hAA);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && stall; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    chk("R2 scoreboard empty", 8'(exp_cfg.size()), 8'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    rd(0, rv); chk("R10 reset state ctrl", rv, 8'h00);
    chk("R4 reset stall", {7'd0, stall}, 8'd0);

    // R3: key register holds nothing
    wr(1, 8'h55); rd(1, rv); chk("R3 key read", rv, 8'h00);
    rd(2, rv); chk("R3 unused read", rv, 8'h00);

    // R2: start without key
    wr(0, 8'h03); rd(0, rv); chk("R2 no key start", rv, 8'h02);

    // R1: key but WEN clear in start byte
    keys(); wr(0, 8'h01); rd(0, rv); chk("R1 wen clear", rv, 8'h00);

    // good write, program space
    wr(0, 8'h02);
    exp_cfg.push_back(1'b0);
    keys(); wr(0, 8'h03);
    chk("R4 stall high", {6'd0, stall, prog_req}, 8'h03);
    wr(0, 8'h02);
    rd(0, rv); chk("R5 start not cleared by sw", rv, 8'h03);
    wait_idle();
    chk("R4 stall low after done", {7'd0, stall}, 8'd0);
    rd(0, rv); chk("R5 start self-clear", rv, 8'h02);

    // R8: no fresh key
    wr(0, 8'h03); rd(0, rv); chk("R8 rearm needed", rv, 8'h02);

    // R7: broken sequences
    wr(1, 8'h55); wr(0, 8'h02); wr(1, 8'hAA); wr(0, 8'h03);
    rd(0, rv); chk("R7 other reg between keys", rv, 8'h02);
    wr(1, 8'h55); wr(1, 8'h56); wr(1, 8'hAA); wr(0, 8'h03);
    rd(0, rv); chk("R7 wrong value", rv, 8'h02);
    keys(); wr(2, 8'h00); wr(0, 8'h03);
    rd(0, rv); chk("R7 write before start", rv, 8'h02);

    // R9: config space write, cfg kept during busy
    exp_cfg.push_back(1'b1);
    keys(); wr(0, 8'h0B);
    wr(0, 8'h02);
    rd(0, rv); chk("R9 cfg held during write", rv, 8'h0B);
    chk("R9 prog_cfg level", {7'd0, prog_cfg}, 8'd1);
    wait_idle();

    // R6: abort by system reset
    exp_cfg.push_back(1'b0);
    keys(); wr(0, 8'h03);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R6 stall dropped", {7'd0, stall}, 8'd0);
    rd(0, rv); chk("R6 err set", rv, 8'h04);

    // R10: sticky error
    wr(0, 8'h04); rd(0, rv); chk("R10 write one keeps", rv, 8'h04);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(0, rv); chk("R10 survives rst_n", rv, 8'h04);
    wr(0, 8'h00); rd(0, rv); chk("R10 sw clear", rv, 8'h00);

    // R8 after abort, then R10 por clear
    wr(0, 8'h03); rd(0, rv); chk("R8 rearm after abort", rv, 8'h02);
    exp_cfg.push_back(1'b0);
    keys(); wr(0, 8'h03);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(0, rv); chk("R6 second abort", rv, 8'h04);
    @(negedge clk); por_n = 0; @(negedge clk); por_n = 1;
    rd(0, rv); chk("R10 por clears", rv, 8'h00);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule